// File: doc/BRIEF.md
# Sample-Rate Output Decimator

This block sits between the corrected conversion words of a pipelined converter and the output pads. On every falling edge of the sample clock it can take one 12-bit result from its input and put it into a registered output bus, and it drives an output clock that tells the pad side when the bus is stable. Two enable pins pick how many results reach the pads: all of them, one in every 8, or one in every 16. Passing fewer words means fewer pad toggles, and with them less switching noise near the analog front end.

At full rate the output clock is the sample clock, gated by a ready flag. In the two slower rates a divided clock is registered inside the block. It is low for the first half of each forwarded word's slot and high for the second half, so its rising edge falls in the middle of the word's hold time. When the enable selection changes, the block restarts its phase. When the converter enable drops, the block clears and stops. After the converter enable returns, a fixed warm-up interval passes before any word is forwarded.

Top module: `odec_top`

## Requirements
- R1: With both rate enables low, every valid input word is forwarded at the falling edge that samples it. Once warm-up is over, `out_clk_o` equals `clk_i`.
- R2: With `dec_a_en_i` high, the first valid word after a phase restart is forwarded. After that, every 8th valid word is forwarded and the rest are dropped.
- R3: With only `dec_b_en_i` high, the rule of R2 applies with a spacing of 16 valid words.
- R4: With both rate enables high, the divide-by-8 rate applies. Switching between "only `dec_a_en_i`" and "both high" is not a rate change and does not restart the phase.
- R5: A cycle with `in_valid_i` low changes neither the output bus nor the decimation phase.
- R6: The output bus changes only on a falling edge of `clk_i`. It keeps its value through the rising edge and the high phase that follow.
- R7: In a divided rate, `out_clk_o` is low from the falling edge that forwards a word until R/2 further valid words have been taken (R = 8 or 16), and high afterwards. After a phase restart it stays high until the first forwarded word.
- R8: A falling edge at which the effective rate differs from the previous edge's rate forwards nothing and restarts the phase. The next valid word is then forwarded.
- R9: A falling edge with `conv_en_i` low clears the output bus to zero and drives `out_clk_o` low. It also re-arms the warm-up.
- R10: After `conv_en_i` rises, the first 8 falling edges with it high forward nothing and keep `out_clk_o` low. The 9th falling edge forwards a valid word and enables the output clock.
- R11: While `rst_ni` is low, the output bus is zero, `out_clk_o` is low and the warm-up is armed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sample clock; state changes on its falling edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| conv_en_i | input | 1 | Converter enable; low powers the block down |
| dec_a_en_i | input | 1 | Selects one word in 8 (has priority) |
| dec_b_en_i | input | 1 | Selects one word in 16 |
| in_data_i | input | 12 | Corrected conversion word |
| in_valid_i | input | 1 | Qualifies `in_data_i` |
| out_data_o | output | 12 | Registered word to the pads |
| out_clk_o | output | 1 | Output clock matched to the output rate |

## Verification
If the phase counter is off by one, the wrong input word appears on the bus within one output period of 8 or 16 words. The output clock's low-to-high point also moves away from mid-slot at the same time. If the rate decode or the restart detection is wrong, the R2/R4 sequences show it at the first word after a mode switch. A wrong warm-up count shows at the 8th or 9th falling edge after the enable rises, because a word either appears one edge early or is missing. A stuck power-down path leaves a non-zero bus after the enable drops.

// File: rtl/odec_pkg.sv
`timescale 1ns/1ps
package odec_pkg;

    typedef enum logic [1:0] {
        RATE_FULL  = 2'd0,
        RATE_DIV_A = 2'd1,
        RATE_DIV_B = 2'd2
    } rate_e;

endpackage

// File: rtl/odec_rate_sel.sv
`timescale 1ns/1ps
// Resolves the two rate enables into one effective rate and flags the
// edge at which that rate differs from the one seen at the previous edge.
module odec_rate_sel
    import odec_pkg::*;
(
    input  logic  clk_i,
    input  logic  rst_ni,
    input  logic  sel_a_i,
    input  logic  sel_b_i,
    output rate_e rate_o,
    output rate_e rate_q_o,
    output logic  chg_o
);

    typedef struct packed {
        rate_e mode;
    } sel_st_t;

    sel_st_t s_d, s_q;
    rate_e   cur;

    always_comb begin
        if (sel_a_i) begin
            cur = RATE_DIV_A;
        end else if (sel_b_i) begin
            cur = RATE_DIV_B;
        end else begin
            cur = RATE_FULL;
        end
        s_d      = s_q;
        s_d.mode = cur;
    end

    always_ff @(negedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            s_q <= '{mode: RATE_FULL};
        end else begin
            s_q <= s_d;
        end
    end

    assign rate_o   = cur;
    assign rate_q_o = s_q.mode;
    assign chg_o    = (cur != s_q.mode);

    // R4: divide-by-8 enable wins over divide-by-16
    assert_prio_a_R4: assert property (@(negedge clk_i) disable iff (!rst_ni)
        (sel_a_i && sel_b_i) |=> (rate_q_o == RATE_DIV_A));

endmodule

// File: rtl/odec_warmup.sv
`timescale 1ns/1ps
// Power-on holdoff: counts falling edges with the enable high and opens
// the forwarding path only after WARM_CYC of them.
module odec_warmup #(
    parameter int unsigned WARM_CYC = 8
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic on_i,
    output logic open_o,
    output logic ready_o
);

    localparam int unsigned CW = $clog2(WARM_CYC + 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          ready;
    } warm_st_t;

    warm_st_t w_d, w_q;

    always_comb begin
        w_d = w_q;
        if (!on_i) begin
            w_d.cnt   = CW'(WARM_CYC);
            w_d.ready = 1'b0;
        end else begin
            if (w_q.cnt != '0) begin
                w_d.cnt = w_q.cnt - 1'b1;
            end
            w_d.ready = (w_q.cnt == '0);
        end
    end

    always_ff @(negedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            w_q <= '{cnt: CW'(WARM_CYC), ready: 1'b0};
        end else begin
            w_q <= w_d;
        end
    end

    assign open_o  = (w_q.cnt == '0);
    assign ready_o = w_q.ready;

    // R9: enable low shuts the output clock at the next edge
    assert_pd_ready_R9: assert property (@(negedge clk_i) disable iff (!rst_ni)
        !on_i |=> (!ready_o && !open_o));

    // R10: the edge where the enable rises never forwards
    assert_rise_closed_R10: assert property (@(negedge clk_i) disable iff (!rst_ni)
        $rose(on_i) |-> !open_o);

endmodule

// File: rtl/odec_phase.sv
`timescale 1ns/1ps
// Decimation phase: counts accepted valid words modulo the rate, picks
// the forwarded ones and registers the divided output clock.
module odec_phase
    import odec_pkg::*;
#(
    parameter int unsigned RATE_A = 8,
    parameter int unsigned RATE_B = 16
) (
    input  logic  clk_i,
    input  logic  rst_ni,
    input  rate_e rate_i,
    input  logic  chg_i,
    input  logic  on_i,
    input  logic  open_i,
    input  logic  valid_i,
    output logic  fwd_o,
    output logic  div_o
);

    localparam int unsigned RMAX = (RATE_A > RATE_B) ? RATE_A : RATE_B;
    localparam int unsigned PW   = (RMAX > 2) ? $clog2(RMAX) : 1;

    typedef struct packed {
        logic [PW-1:0] ph;
        logic          div;
    } ph_st_t;

    ph_st_t p_d, p_q;
    int unsigned rate_n;
    logic [PW-1:0] last;

    always_comb begin
        case (rate_i)
            RATE_DIV_A: rate_n = RATE_A;
            RATE_DIV_B: rate_n = RATE_B;
            default:    rate_n = 1;
        endcase
        last  = PW'(rate_n - 1);
        fwd_o = open_i && on_i && valid_i && !chg_i && (p_q.ph == '0);

        p_d = p_q;
        if (!open_i || !on_i || chg_i) begin
            p_d.ph = '0;
        end else if (valid_i) begin
            p_d.ph = (p_q.ph == last) ? '0 : p_q.ph + 1'b1;
        end
        p_d.div = on_i && open_i &&
                  ((32'(p_d.ph) > rate_n / 2) || (p_d.ph == '0));
    end

    always_ff @(negedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            p_q <= '{ph: '0, div: 1'b0};
        end else begin
            p_q <= p_d;
        end
    end

    assign div_o = p_q.div;

    // R2 / R3: phase never leaves the range of the active rate
    assert_ph_bound_R2: assert property (@(negedge clk_i) disable iff (!rst_ni)
        !chg_i |-> (32'(p_q.ph) < rate_n));

    // R8: a restart edge leaves the phase at zero
    assert_restart_R8: assert property (@(negedge clk_i) disable iff (!rst_ni)
        chg_i |=> (p_q.ph == '0));

endmodule

// File: rtl/odec_top.sv
`timescale 1ns/1ps
module odec_top
    import odec_pkg::*;
#(
    parameter int unsigned DATA_W   = 12,
    parameter int unsigned RATE_A   = 8,
    parameter int unsigned RATE_B   = 16,
    parameter int unsigned WARM_CYC = 8
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              conv_en_i,
    input  logic              dec_a_en_i,
    input  logic              dec_b_en_i,
    input  logic [DATA_W-1:0] in_data_i,
    input  logic              in_valid_i,
    output logic [DATA_W-1:0] out_data_o,
    output logic              out_clk_o
);

    typedef struct packed {
        logic [DATA_W-1:0] data;
    } out_st_t;

    out_st_t o_d, o_q;
    rate_e   rate_cur;
    rate_e   rate_reg;
    logic    mode_chg;
    logic    win_open;
    logic    ready;
    logic    fwd;
    logic    div_clk;

    odec_rate_sel i_rate_sel (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .sel_a_i  (dec_a_en_i),
        .sel_b_i  (dec_b_en_i),
        .rate_o   (rate_cur),
        .rate_q_o (rate_reg),
        .chg_o    (mode_chg)
    );

    odec_warmup #(
        .WARM_CYC (WARM_CYC)
    ) i_warmup (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .on_i    (conv_en_i),
        .open_o  (win_open),
        .ready_o (ready)
    );

    odec_phase #(
        .RATE_A (RATE_A),
        .RATE_B (RATE_B)
    ) i_phase (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .rate_i  (rate_cur),
        .chg_i   (mode_chg),
        .on_i    (conv_en_i),
        .open_i  (win_open),
        .valid_i (in_valid_i),
        .fwd_o   (fwd),
        .div_o   (div_clk)
    );

    always_comb begin
        o_d = o_q;
        if (!conv_en_i) begin
            o_d.data = '0;
        end else if (fwd) begin
            o_d.data = in_data_i;
        end
    end

    always_ff @(negedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            o_q <= '{data: '0};
        end else begin
            o_q <= o_d;
        end
    end

    assign out_data_o = o_q.data;
    // ready and rate_reg change only while clk_i is low, so the gate is clean
    assign out_clk_o  = (rate_reg == RATE_FULL) ? (clk_i & ready) : div_clk;

    // R5: an idle input cycle leaves the bus untouched
    assert_idle_hold_R5: assert property (@(negedge clk_i) disable iff (!rst_ni)
        (conv_en_i && !in_valid_i) |=> $stable(out_data_o));

    // R8: the restart edge forwards nothing
    assert_chg_drop_R8: assert property (@(negedge clk_i) disable iff (!rst_ni)
        (conv_en_i && mode_chg) |=> $stable(out_data_o));

    // R9: power-down clears the bus
    assert_pd_clear_R9: assert property (@(negedge clk_i) disable iff (!rst_ni)
        !conv_en_i |=> (out_data_o == '0));

    // R10: no word passes while warm-up is still running
    assert_warm_hold_R10: assert property (@(negedge clk_i) disable iff (!rst_ni)
        (conv_en_i && !win_open) |=> $stable(out_data_o));

endmodule

// File: tb/test_odec_top.sv
`timescale 1ns/1ps
module test_odec_top;

    logic        clk_i = 1'b0;
    logic        rst_ni = 1'b0;
    logic        conv_en_i = 1'b0;
    logic        dec_a_en_i = 1'b0;
    logic        dec_b_en_i = 1'b0;
    logic [11:0] in_data_i = '0;
    logic        in_valid_i = 1'b0;
    logic [11:0] out_data_o;
    logic        out_clk_o;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    // model state
    int          m_rate = 1;
    int          m_since = 0;
    bit          m_pend = 1'b0;
    bit          m_chg = 1'b0;
    logic [11:0] m_data = '0;
    int          seq = 0;

    localparam int VEC_N = 6;
    // {dec_b, dec_a}
    localparam logic [1:0] VEC_SEL [VEC_N] = '{2'b01, 2'b11, 2'b10, 2'b00, 2'b10, 2'b01};
    localparam int         VEC_LEN [VEC_N] = '{20, 12, 40, 6, 36, 17};
    localparam bit         VEC_GAP [VEC_N] = '{1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0};

    odec_top i_odec_top (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .conv_en_i  (conv_en_i),
        .dec_a_en_i (dec_a_en_i),
        .dec_b_en_i (dec_b_en_i),
        .in_data_i  (in_data_i),
        .in_valid_i (in_valid_i),
        .out_data_o (out_data_o),
        .out_clk_o  (out_clk_o)
    );

    always #4 clk_i = ~clk_i;

    task automatic chk(input string req, input string what,
                       input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s %s: got %0h expected %0h", req, what, got, exp);
        end
    endtask

    function automatic logic [11:0] next_word();
        seq++;
        return 12'((seq * 173 + 5) & 12'hFFF);
    endfunction

    // called at posedge+1; returns at the next posedge+1
    task automatic tick(input bit a, input bit b, input bit v, input logic [11:0] d);
        dec_a_en_i = a;
        dec_b_en_i = b;
        in_valid_i = v;
        in_data_i  = d;
        @(negedge clk_i);
        @(posedge clk_i);
        #1;
    endtask

    task automatic model(input bit a, input bit b, input bit v, input logic [11:0] d);
        int r;
        r = a ? 8 : (b ? 16 : 1);
        m_chg = 1'b0;
        if (r != m_rate) begin
            m_rate = r;
            m_pend = 1'b1;
            m_chg  = 1'b1;
        end else if (v) begin
            if (m_pend) begin
                m_pend = 1'b0;
                m_since = 0;
                m_data = d;
            end else begin
                m_since++;
                if (m_since == m_rate) begin
                    m_since = 0;
                    m_data = d;
                end
            end
        end
    endtask

    function automatic bit model_clk();
        return m_pend || (m_since >= m_rate / 2);
    endfunction

    initial begin
        #(200000 * 8);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        logic [11:0] d;
        string req;
        // reset state
        repeat (3) @(posedge clk_i);
        #1;
        chk("R11", "reset data", 32'(out_data_o), 0);
        chk("R11", "reset clk", 32'(out_clk_o), 0);
        rst_ni = 1'b1;
        tick(0, 0, 1, 12'h5A5);
        chk("R9", "disabled data", 32'(out_data_o), 0);

        // warm-up at full rate
        conv_en_i = 1'b1;
        for (int k = 1; k <= 8; k++) begin
            tick(0, 0, 1, next_word());
            chk("R10", "warm data", 32'(out_data_o), 0);
            chk("R10", "warm clk", 32'(out_clk_o), 0);
        end
        d = next_word();
        tick(0, 0, 1, d);
        m_rate = 1; m_pend = 1'b0; m_since = 0; m_data = d;
        chk("R10", "first word", 32'(out_data_o), 32'(d));
        chk("R1", "clk follows", 32'(out_clk_o), 1);

        // falling-edge update
        d = next_word();
        in_data_i = d;
        #1;
        chk("R6", "hold before fall", 32'(out_data_o), 32'(m_data));
        @(negedge clk_i);
        #1;
        chk("R6", "after fall", 32'(out_data_o), 32'(d));
        chk("R1", "clk low phase", 32'(out_clk_o), 0);
        @(posedge clk_i);
        #1;
        model(0, 0, 1, d);

        // table walk
        for (int e = 0; e < VEC_N; e++) begin
            for (int i = 0; i < VEC_LEN[e]; i++) begin
                bit v;
                v = !(VEC_GAP[e] && (i % 3 == 2));
                d = next_word();
                tick(VEC_SEL[e][0], VEC_SEL[e][1], v, d);
                model(VEC_SEL[e][0], VEC_SEL[e][1], v, d);
                if (m_chg) req = "R8";
                else if (!v) req = "R5";
                else if (VEC_SEL[e] == 2'b11) req = "R4";
                else if (VEC_SEL[e][0]) req = "R2";
                else if (VEC_SEL[e][1]) req = "R3";
                else req = "R1";
                chk(req, "data", 32'(out_data_o), 32'(m_data));
                chk((m_rate == 1) ? "R1" : "R7", "out clk", 32'(out_clk_o), 32'(model_clk()));
            end
        end

        // power down
        conv_en_i = 1'b0;
        tick(0, 0, 1, next_word());
        chk("R9", "pd data", 32'(out_data_o), 0);
        chk("R9", "pd clk", 32'(out_clk_o), 0);

        // rewarm at divide-by-16
        conv_en_i = 1'b1;
        for (int k = 1; k <= 8; k++) begin
            tick(0, 1, 1, next_word());
            chk("R10", "rewarm data", 32'(out_data_o), 0);
            chk("R10", "rewarm clk", 32'(out_clk_o), 0);
        end
        m_rate = 16; m_pend = 1'b1; m_since = 0;
        for (int k = 0; k < 20; k++) begin
            d = next_word();
            tick(0, 1, 1, d);
            model(0, 1, 1, d);
            chk("R3", "rewarm data", 32'(out_data_o), 32'(m_data));
            chk("R7", "rewarm clk", 32'(out_clk_o), 32'(model_clk()));
        end

        finished = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule